// File: doc/BRIEF.md
# Overflow Interrupt Timer

A register-programmed peripheral holding two identical 32-bit up-counting timer channels behind one simple bus port. Each channel counts up from a software-loaded preload value at a rate set by its own prescaler. When the count passes all ones it wraps to zero, keeps running and latches a sticky pending flag. That flag can drive a level interrupt line, one line per channel.

A timeout of N+1 ticks is set by loading the preload register with all-ones minus N, issuing a reset-and-hold command and then a start command. The commands live in a control register, while the timer-enable and interrupt-enable bits live in a separate configuration register. Reads are combinational in the cycle the address is presented. Writes take effect at the clock edge of the access cycle.

Top module: `ovf_timer_top`

## Requirements
- R1: After reset every register of every channel reads zero and every interrupt line is low.
- R2: Within a channel the byte offsets are status 0x00 (bit 0 = pending flag), count 0x04, control 0x10, configuration 0x20, divider 0x24 and preload 0x28. Preload, divider (lower 16 bits) and configuration (bits 1:0) read back what was written, and control bit 1 reads back as the running state.
- R3: Offsets not listed in R2 read zero and ignore writes, and the count register ignores writes.
- R4: A control write with bit 0 set halts counting, loads the preload value into the count and restarts the prescaler. Bit 0 takes precedence over bit 1 in the same write.
- R5: A control write with bit 1 set (bit 0 clear) starts counting up from the current count, and a control write of 0 stops the count and holds its value.
- R6: With divider value D the count advances once every D+1 clocks. The first advance comes D+1 clocks after the start command.
- R7: The count advances only while configuration bit 0 (timer enable) is set.
- R8: With preload 0xFFFFFFFF-N, after reset and start the count reaches 0xFFFFFFFF after N ticks. The next tick sets the pending flag, wraps the count to zero, and counting continues.
- R9: The pending flag stays set until a status write with bit 0 set, and a status write with bit 0 clear has no effect.
- R10: When an overflow and a status clear happen in the same cycle, the flag stays set.
- R11: Each interrupt line is high exactly while that channel's flag, interrupt enable (configuration bit 1) and timer enable (configuration bit 0) are all set.
- R12: The second channel sits at byte offset 0x40 above the first, with the same layout, and operates independently of the first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access strobe for the current cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Byte address within the timer window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when not selected |
| irq | output | 2 | Level interrupt, one bit per channel |

## Verification
Read data is due in the same cycle as the address, so reads are sampled one time step after the address is driven, away from the clock edge. A register write lands at the single edge inside its access cycle. With a zero divider, the count after the start edge k is preload+j after edge k+j, and the flag and interrupt change right after the overflow edge. With divider D, advances fall on edges k+(D+1)m. The bench drives and samples only on falling edges and counts the edges between start and each sample, so that every expected value follows from the requirements.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int BUS_W        = 32;
   localparam int OFS_W        = 6;
   localparam logic [OFS_W-1:0] OFS_STAT = 6'h00;
   localparam logic [OFS_W-1:0] OFS_CNT  = 6'h04;
   localparam logic [OFS_W-1:0] OFS_CTRL = 6'h10;
   localparam logic [OFS_W-1:0] OFS_CFG  = 6'h20;
   localparam logic [OFS_W-1:0] OFS_DIV  = 6'h24;
   localparam logic [OFS_W-1:0] OFS_LOAD = 6'h28;

   typedef struct packed {
      logic             wr;
      logic [OFS_W-1:0] ofs;
      logic [BUS_W-1:0] wdata;
   } ch_req_t;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] pcnt;
   logic             term;

   assign term = (pcnt >= div);
   assign tick = run && !restart && term;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pcnt <= '0;
      else if (restart) pcnt <= '0;
      else if (run)     pcnt <= term ? '0 : pcnt + 1'b1;
   end

   // R6: with a nonzero divider two ticks never come back to back
   p_tick_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && div != '0) |=> (!tick || div != $past(div)));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
   import tmr_pkg::*;
#(
   parameter int CNT_W       = 32,
   parameter int DIV_W       = 16,
   parameter bit PRESCALE_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  ch_req_t          req,
   output logic [BUS_W-1:0] rdata,
   output logic             irq
);
   logic             flag, running, cfg_en, cfg_ie;
   logic [CNT_W-1:0] count, load;
   logic             wr_stat, wr_ctrl, wr_cfg, wr_load;
   logic             ctrl_rst, count_en, tick, wrap, clr;
   logic [BUS_W-1:0] div_rd;

   assign wr_stat  = req.wr && (req.ofs == OFS_STAT);
   assign wr_ctrl  = req.wr && (req.ofs == OFS_CTRL);
   assign wr_cfg   = req.wr && (req.ofs == OFS_CFG);
   assign wr_load  = req.wr && (req.ofs == OFS_LOAD);
   assign ctrl_rst = wr_ctrl && req.wdata[0];
   assign clr      = wr_stat && req.wdata[0];
   assign count_en = running && cfg_en;
   assign wrap     = tick && (count == {CNT_W{1'b1}});

   generate
      if (PRESCALE_EN) begin : g_pre
         logic [DIV_W-1:0] divr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              divr <= '0;
            else if (req.wr && req.ofs == OFS_DIV)   divr <= req.wdata[DIV_W-1:0];
         end
         assign div_rd = BUS_W'(divr);
         tmr_prescale #(.DIV_W(DIV_W)) i_pre (
            .clk(clk), .rst_n(rst_n), .run(count_en), .restart(ctrl_rst),
            .div(divr), .tick(tick));
      end else begin : g_nopre
         assign div_rd = '0;
         assign tick   = count_en && !ctrl_rst;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running <= 1'b0;
         cfg_en  <= 1'b0;
         cfg_ie  <= 1'b0;
         load    <= '0;
      end else begin
         if (wr_ctrl) running <= req.wdata[1] && !req.wdata[0];
         if (wr_cfg) begin
            cfg_en <= req.wdata[0];
            cfg_ie <= req.wdata[1];
         end
         if (wr_load) load <= req.wdata[CNT_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        count <= '0;
      else if (ctrl_rst) count <= load;
      else if (tick)     count <= count + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    flag <= 1'b0;
      else if (wrap) flag <= 1'b1;
      else if (clr)  flag <= 1'b0;
   end

   assign irq = flag && cfg_ie && cfg_en;

   always_comb begin
      unique case (req.ofs)
         OFS_STAT: rdata = {{(BUS_W-1){1'b0}}, flag};
         OFS_CNT:  rdata = BUS_W'(count);
         OFS_CTRL: rdata = {{(BUS_W-2){1'b0}}, running, 1'b0};
         OFS_CFG:  rdata = {{(BUS_W-2){1'b0}}, cfg_ie, cfg_en};
         OFS_DIV:  rdata = div_rd;
         OFS_LOAD: rdata = BUS_W'(load);
         default:  rdata = '0;
      endcase
   end

   p_ovf_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (count == '0 && flag));
   p_ovf_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap && clr) |=> flag);
   p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr) |=> flag);
   p_reset_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_rst |=> (count == $past(load) && !running));
   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !ctrl_rst) |=> $stable(count));
   p_need_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_en |-> !tick);
endmodule

// File: rtl/ovf_timer_top.sv
module ovf_timer_top
   import tmr_pkg::*;
#(
   parameter int NUM_CH      = 2,
   parameter int ADDR_W      = 7,
   parameter int CNT_W       = 32,
   parameter int DIV_W       = 16,
   parameter bit PRESCALE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic [NUM_CH-1:0] irq
);
   localparam int CH_IDX_W = ADDR_W - OFS_W;

   generate
      if (ADDR_W <= OFS_W || CH_IDX_W < $clog2(NUM_CH))
         $error("ovf_timer_top: ADDR_W too small for NUM_CH channels");
      if (CNT_W < 2 || CNT_W > BUS_W)
         $error("ovf_timer_top: CNT_W must be 2..32");
      if (DIV_W < 1 || DIV_W > BUS_W)
         $error("ovf_timer_top: DIV_W must be 1..32");
   endgenerate

   logic [CH_IDX_W-1:0] ch_idx;
   logic [BUS_W-1:0]    ch_rdata [NUM_CH];

   assign ch_idx = bus_addr[ADDR_W-1:OFS_W];

   generate
      for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
         ch_req_t req;
         assign req.wr    = bus_sel && bus_we && (ch_idx == CH_IDX_W'(g));
         assign req.ofs   = bus_addr[OFS_W-1:0];
         assign req.wdata = bus_wdata;
         tmr_channel #(.CNT_W(CNT_W), .DIV_W(DIV_W), .PRESCALE_EN(PRESCALE_EN)) i_ch (
            .clk(clk), .rst_n(rst_n), .req(req), .rdata(ch_rdata[g]), .irq(irq[g]));
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      for (int c = 0; c < NUM_CH; c++)
         if (bus_sel && ch_idx == CH_IDX_W'(c)) bus_rdata = ch_rdata[c];
   end

   // R1: interrupts are low in the first cycle after reset
   p_irq_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (irq == '0));
endmodule

// File: tb/test_ovf_timer_top.sv
module test_ovf_timer_top;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_we = 1'b0;
   logic [6:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [1:0]  irq;

   int n_chk = 0, n_err = 0;
   bit done = 0;

   always #(CLK_P/2) clk = ~clk;

   ovf_timer_top i_ovf_timer_top (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

   typedef struct packed {
      logic [6:0]  a;
      logic [31:0] w;
      logic [31:0] e;
   } vec_t;

   // write then read back; R2 readback, R3 undefined, R12 channel two
   localparam vec_t VEC [12] = '{
      '{7'h28, 32'h1234_5678, 32'h1234_5678},
      '{7'h24, 32'hFFFF_ABCD, 32'h0000_ABCD},
      '{7'h20, 32'hFFFF_FFFF, 32'h0000_0003},
      '{7'h20, 32'h0000_0000, 32'h0000_0000},
      '{7'h00, 32'h0000_0000, 32'h0000_0000},
      '{7'h08, 32'hDEAD_BEEF, 32'h0000_0000},
      '{7'h2C, 32'hDEAD_BEEF, 32'h0000_0000},
      '{7'h3C, 32'hDEAD_BEEF, 32'h0000_0000},
      '{7'h68, 32'hCAFE_F00D, 32'hCAFE_F00D},
      '{7'h64, 32'h0000_0007, 32'h0000_0007},
      '{7'h60, 32'h0000_0002, 32'h0000_0002},
      '{7'h48, 32'h5555_5555, 32'h0000_0000}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %08h expected %08h", req, act, exp);
      end
   endtask

   // called on a falling edge; the write lands on the next rising edge
   task automatic wr(input logic [6:0] a, input logic [31:0] d);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input logic [6:0] a, output logic [31:0] d);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic summary;
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   endtask

   initial begin
      #(CLK_P*200000);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      logic [31:0] v;
      idle(3);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      foreach (VEC[i]) begin
         rd(VEC[i].a, v);
         chk("R1 reset reg", v, 32'h0);
      end
      rd(7'h04, v); chk("R1 reset count", v, 32'h0);
      rd(7'h10, v); chk("R1 reset ctrl", v, 32'h0);
      chk("R1 reset irq", {30'h0, irq}, 32'h0);

      // table walk
      foreach (VEC[i]) begin
         wr(VEC[i].a, VEC[i].w);
         rd(VEC[i].a, v);
         chk("R2/R3/R12 readback", v, VEC[i].e);
      end
      rd(7'h28, v); chk("R12 channel one preload untouched", v, 32'h1234_5678);
      wr(7'h64, 32'h0);

      // R4 reset loads preload; R3 count write ignored
      wr(7'h10, 32'h1);
      rd(7'h04, v); chk("R4 reset loads preload", v, 32'h1234_5678);
      wr(7'h04, 32'h0000_0055);
      rd(7'h04, v); chk("R3 count write ignored", v, 32'h1234_5678);

      // R7 no counting without enable
      wr(7'h24, 32'h0);
      wr(7'h10, 32'h2);
      rd(7'h10, v); chk("R2 ctrl running readback", v, 32'h2);
      idle(5);
      rd(7'h04, v); chk("R7 disabled holds", v, 32'h1234_5678);

      // R5 counting and stop
      wr(7'h20, 32'h1);              // edge k: enable, counting from next edge
      idle(4);
      rd(7'h04, v); chk("R5 counts up", v, 32'h1234_567C);
      wr(7'h10, 32'h0);              // tick at this edge, then stop
      rd(7'h04, v); chk("R5 last tick", v, 32'h1234_567D);
      idle(4);
      rd(7'h04, v); chk("R5 stop holds", v, 32'h1234_567D);
      wr(7'h10, 32'h3);
      rd(7'h10, v); chk("R4 reset beats start", v, 32'h0);

      // R6 divider 2
      wr(7'h28, 32'h0);
      wr(7'h24, 32'h2);
      wr(7'h10, 32'h1);
      wr(7'h10, 32'h2);              // edge k
      idle(2);
      rd(7'h04, v); chk("R6 no tick before D+1", v, 32'h0);
      idle(1);
      rd(7'h04, v); chk("R6 first tick", v, 32'h1);
      idle(2);
      rd(7'h04, v); chk("R6 between ticks", v, 32'h1);
      idle(1);
      rd(7'h04, v); chk("R6 second tick", v, 32'h2);

      // R8 overflow, R10 and R9
      wr(7'h24, 32'h0);
      wr(7'h28, 32'hFFFF_FFFC);      // N = 3
      wr(7'h10, 32'h1);
      wr(7'h10, 32'h2);              // edge k
      idle(3);
      rd(7'h04, v); chk("R8 all ones after N", v, 32'hFFFF_FFFF);
      rd(7'h00, v); chk("R8 no flag yet", v, 32'h0);
      wr(7'h00, 32'h1);              // edge k+4: overflow with clear
      rd(7'h00, v); chk("R10 overflow wins", v, 32'h1);
      rd(7'h04, v); chk("R8 wraps to zero", v, 32'h0);
      wr(7'h00, 32'h0);
      rd(7'h00, v); chk("R9 zero write no effect", v, 32'h1);
      wr(7'h00, 32'h1);
      rd(7'h00, v); chk("R9 clear", v, 32'h0);
      rd(7'h04, v); chk("R8 keeps running", v, 32'h2);
      chk("R11 irq low when ie clear", {30'h0, irq}, 32'h0);

      // R11 interrupt gating, N = 0 boundary
      wr(7'h10, 32'h0);
      wr(7'h28, 32'hFFFF_FFFF);
      wr(7'h20, 32'h3);
      wr(7'h10, 32'h1);
      wr(7'h10, 32'h2);              // edge k
      wr(7'h10, 32'h0);              // edge k+1: overflow, then stop
      rd(7'h00, v); chk("R8 N=0 overflow", v, 32'h1);
      chk("R11 irq high", {30'h0, irq}, 32'h1);
      wr(7'h20, 32'h1);
      chk("R11 ie off", {30'h0, irq}, 32'h0);
      wr(7'h20, 32'h2);
      chk("R11 en off", {30'h0, irq}, 32'h0);
      wr(7'h20, 32'h3);
      chk("R11 irq back", {30'h0, irq}, 32'h1);

      // R12 channel two counts on its own
      rd(7'h40, v); chk("R12 channel two flag clear", v, 32'h0);
      wr(7'h68, 32'hFFFF_FFFE);      // N = 1
      wr(7'h60, 32'h3);
      wr(7'h50, 32'h1);
      wr(7'h50, 32'h2);              // edge k
      idle(1);
      rd(7'h44, v); chk("R12 channel two count", v, 32'hFFFF_FFFF);
      idle(1);
      chk("R12 both irq", {30'h0, irq}, 32'h3);
      wr(7'h00, 32'h1);
      chk("R12 channel one clear only", {30'h0, irq}, 32'h2);

      summary();
   end
endmodule